// File: doc/BRIEF.md
# Load/Store Alignment Exception Detector

This block sits beside the load/store pipeline and inspects every memory access it is shown. From the access class, the low bits of the effective address, the access size, the byte-order mode and the two attributes of the target page, it decides whether the access must trap to the alignment handler. Several rules apply. Some depend only on address misalignment. Others depend on the instruction class, on little-endian mode, or on the caching attributes of the page.

When any rule matches, the block raises a one-cycle exception strobe in the cycle after the access. Alongside the strobe it gives a cause code that the handler can use to tell the rules apart. It also drives the fixed handler vector offset. If several rules match at once, one cause is reported according to a fixed priority. A parameter removes floating-point checking for a variant of the core that has no floating-point unit.

Top module: `aln_detect`

## Requirements
- R1: With floating point enabled (HAS_FP=1), a floating-point access (class 1) whose address bits [1:0] are not 00 raises the exception with cause 4.
- R2: A load/store-multiple (class 2), load-reserved (class 3) or conditional-store (class 4) access whose address bits [1:0] are not 00 raises the exception with cause 5.
- R3: In little-endian mode (le_i=1), an access that is not a multiple of its size raises the exception with cause 3. Sizes are encoded as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes.
- R4: In little-endian mode, a multiple (class 2) or string (class 5) access raises the exception with cause 2, whatever its address.
- R5: A cache-block-zero access (class 6) to a page marked write-through or caching-inhibited raises the exception with cause 1.
- R6: When several rules hold at once, the reported cause is the highest-priority one. The order is cause 1, then 2, then 3, then 4, then 5.
- R7: vec_o always equals 0x00600.
- R8: With HAS_FP=0, a floating-point access (class 1) never raises the exception.
- R9: exc_o and cause_o are registered. They reflect the access presented one cycle earlier, and an access is seen only while valid_i=1. cause_o is 0 whenever exc_o is 0, and both are 0 after reset.
- R10: Integer (class 0) and string accesses in big-endian mode, and cache-block-zero accesses to ordinary pages in big-endian mode, never raise the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Access presented this cycle |
| cls_i | input | 3 | Access class: 0 int, 1 fp, 2 multiple, 3 reserved load, 4 conditional store, 5 string, 6 block zero |
| addr_lo_i | input | 3 | Effective address bits [2:0] |
| size_i | input | 2 | log2 of the access size in bytes |
| le_i | input | 1 | Little-endian mode |
| wt_i | input | 1 | Page is write-through |
| ci_i | input | 1 | Page is caching-inhibited |
| exc_o | output | 1 | Alignment exception strobe |
| vec_o | output | VEC_W | Handler vector offset |
| cause_o | output | 3 | Cause code, 0 when no exception |

## Verification
The checker holds a number of properties on every cycle. It confirms that a strobe is always caused by a valid access in the cycle before, that the cause is nonzero exactly when the strobe is high, and that block-zero page faults and little-endian multiple/string accesses always trap with the expected cause. It also confirms that integer accesses in big-endian mode, and floating-point accesses in the no-FP variant, never trap. Exact cause values for address, size and page combinations, including the priority between overlapping rules, are shown by the bench's full sweep over every class, address, size, mode and page setting on both variants.

// File: rtl/aln_pkg.sv
package aln_pkg;
  localparam int LO_W    = 3;
  localparam int CLS_W   = 3;
  localparam int CAUSE_W = 3;
  localparam int NCOND   = 5;

  typedef enum logic [CLS_W-1:0] {
    AC_INT    = 3'd0,
    AC_FP     = 3'd1,
    AC_MULTI  = 3'd2,
    AC_RSV    = 3'd3,
    AC_CSTORE = 3'd4,
    AC_STRING = 3'd5,
    AC_BZERO  = 3'd6,
    AC_UNUSED = 3'd7
  } acc_cls_e;

  // condition bit index i reports cause i+1; lower index wins
  localparam int CB_BZERO  = 0;
  localparam int CB_LEMULT = 1;
  localparam int CB_LEMIS  = 2;
  localparam int CB_FPWORD = 3;
  localparam int CB_WORD   = 4;

  function automatic logic size_misaligned(input logic [LO_W-1:0] lo,
                                           input logic [1:0] sz);
    logic [LO_W-1:0] mask;
    mask = LO_W'((4'd1 << sz) - 4'd1);
    return |(lo & mask);
  endfunction

  function automatic logic word_misaligned(input logic [LO_W-1:0] lo);
    return |lo[1:0];
  endfunction
endpackage

// File: rtl/aln_cond.sv
module aln_cond
  import aln_pkg::*;
#(
  parameter bit HAS_FP = 1'b1
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic [1:0]       size_i,
  input  logic             le_i,
  input  logic             wt_i,
  input  logic             ci_i,
  output logic [NCOND-1:0] cond_o
);
  acc_cls_e cls;
  logic     fp_kill;
  logic     is_fp, is_multi, is_sync, is_str, is_bz;
  logic     mis_sz, mis_wd;

  assign cls = acc_cls_e'(cls_i);

  generate
    if (HAS_FP) begin : g_fp
      assign fp_kill = 1'b0;
    end else begin : g_nofp
      assign fp_kill = (cls == AC_FP);
    end
  endgenerate

  assign is_fp    = (cls == AC_FP);
  assign is_multi = (cls == AC_MULTI);
  assign is_sync  = (cls == AC_MULTI) || (cls == AC_RSV) || (cls == AC_CSTORE);
  assign is_str   = (cls == AC_STRING);
  assign is_bz    = (cls == AC_BZERO);
  assign mis_sz   = size_misaligned(lo_i, size_i);
  assign mis_wd   = word_misaligned(lo_i);

  always_comb begin
    cond_o             = '0;
    cond_o[CB_BZERO]   = is_bz && (wt_i || ci_i);
    cond_o[CB_LEMULT]  = le_i && (is_multi || is_str);
    cond_o[CB_LEMIS]   = le_i && mis_sz;
    cond_o[CB_FPWORD]  = is_fp && mis_wd;
    cond_o[CB_WORD]    = is_sync && mis_wd;
    if (fp_kill) cond_o = '0;
  end
endmodule

// File: rtl/aln_prio.sv
module aln_prio
  import aln_pkg::*;
(
  input  logic [NCOND-1:0]   cond_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o = '0;
    for (int i = NCOND - 1; i >= 0; i--) begin
      if (cond_i[i]) cause_o = CAUSE_W'(i + 1);
    end
  end
  assign any_o = |cond_i;
endmodule

// File: rtl/aln_detect.sv
module aln_detect
  import aln_pkg::*;
#(
  parameter bit                HAS_FP     = 1'b1,
  parameter int                VEC_W      = 20,
  parameter logic [VEC_W-1:0]  VEC_OFFSET = 20'h00600
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [CLS_W-1:0]   cls_i,
  input  logic [LO_W-1:0]    addr_lo_i,
  input  logic [1:0]         size_i,
  input  logic               le_i,
  input  logic               wt_i,
  input  logic               ci_i,
  output logic               exc_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NCOND-1:0]   cond_w;
  logic               hit_w;
  logic [CAUSE_W-1:0] cause_w;
  logic               exc_q;
  logic [CAUSE_W-1:0] cause_q;

  aln_cond #(.HAS_FP(HAS_FP)) u_cond (
    .cls_i  (cls_i),
    .lo_i   (addr_lo_i),
    .size_i (size_i),
    .le_i   (le_i),
    .wt_i   (wt_i),
    .ci_i   (ci_i),
    .cond_o (cond_w)
  );

  aln_prio u_prio (
    .cond_i  (cond_w),
    .any_o   (hit_w),
    .cause_o (cause_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      exc_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      exc_q   <= valid_i && hit_w;
      cause_q <= (valid_i && hit_w) ? cause_w : '0;
    end
  end

  assign exc_o   = exc_q;
  assign cause_o = cause_q;
  assign vec_o   = VEC_OFFSET;
endmodule

// File: rtl/aln_chk.sv
module aln_chk
  import aln_pkg::*;
#(
  parameter bit HAS_FP = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [CLS_W-1:0]   cls_i,
  input logic               le_i,
  input logic               wt_i,
  input logic               ci_i,
  input logic               exc_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [NCOND-1:0]   cond_w
);
  p_exc_from_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $past(valid_i));

  p_cause_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> cause_o == '0);

  p_cause_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> cause_o != '0);

  p_bzero_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == AC_BZERO && (wt_i || ci_i)) |=> (exc_o && cause_o == 3'd1));

  p_le_multstr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && le_i && (cls_i == AC_MULTI || cls_i == AC_STRING)) |=>
      (exc_o && cause_o == 3'd2));

  p_int_be_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !le_i && cls_i == AC_INT) |=> !exc_o);

  p_nofp_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !HAS_FP && cls_i == AC_FP) |=> !exc_o);

  p_cond_onehot_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cond_w[CB_WORD:CB_FPWORD]));
endmodule

bind aln_detect aln_chk #(.HAS_FP(HAS_FP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .cls_i   (cls_i),
  .le_i    (le_i),
  .wt_i    (wt_i),
  .ci_i    (ci_i),
  .exc_o   (exc_o),
  .cause_o (cause_o),
  .cond_w  (cond_w)
);

// File: tb/sim_aln_detect.sv
`timescale 1ns/1ps
module sim_aln_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  cls = '0;
  logic [2:0]  lo = '0;
  logic [1:0]  sz = '0;
  logic        le = 1'b0, wt = 1'b0, ci = 1'b0;
  logic        exc0, exc1;
  logic [19:0] vec0, vec1;
  logic [2:0]  cau0, cau1;
  int          checks = 0, errors = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aln_detect #(.HAS_FP(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cls_i(cls), .addr_lo_i(lo),
    .size_i(sz), .le_i(le), .wt_i(wt), .ci_i(ci),
    .exc_o(exc0), .vec_o(vec0), .cause_o(cau0));

  aln_detect #(.HAS_FP(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cls_i(cls), .addr_lo_i(lo),
    .size_i(sz), .le_i(le), .wt_i(wt), .ci_i(ci),
    .exc_o(exc1), .vec_o(vec1), .cause_o(cau1));

  // expected cause, restated arithmetically from the requirements
  function automatic int exp_cause(int c, int a, int s, int l, int w, int i, bit fp);
    int bytes;
    if (c == 1 && !fp) return 0;                          // R8
    bytes = 1 << s;
    if (c == 6 && (w || i)) return 1;                     // R5
    if (l && (c == 2 || c == 5)) return 2;                // R4
    if (l && (a % bytes) != 0) return 3;                  // R3
    if (c == 1 && (a % 4) != 0) return 4;                 // R1
    if ((c >= 2 && c <= 4) && (a % 4) != 0) return 5;     // R2
    return 0;                                             // R10
  endfunction

  function automatic int n_rules(int c, int a, int s, int l, int w, int i);
    int n = 0;
    if (c == 6 && (w || i)) n++;
    if (l && (c == 2 || c == 5)) n++;
    if (l && (a % (1 << s)) != 0) n++;
    if (c == 1 && (a % 4) != 0) n++;
    if ((c >= 2 && c <= 4) && (a % 4) != 0) n++;
    return n;
  endfunction

  function automatic string tag_of(int cause, int nr);
    if (nr > 1) return "R6";
    case (cause)
      1: return "R5";
      2: return "R4";
      3: return "R3";
      4: return "R1";
      5: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, int act_e, int act_c, int exp_e, int exp_c);
    checks++;
    if (act_e != exp_e || act_c != exp_c) begin
      errors++;
      $display("FAIL %s: exc=%0d cause=%0d expected exc=%0d cause=%0d",
               tag, act_e, act_c, exp_e, exp_c);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    while (cyc < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", exc0, cau0, 0, 0);
    check("R7", 0, int'(vec0), 0, 'h600);
    rst_n = 1'b1;
    for (int c = 0; c < 7; c++)
      for (int a = 0; a < 8; a++)
        for (int s = 0; s < 4; s++)
          for (int l = 0; l < 2; l++)
            for (int p = 0; p < 4; p++) begin
              int e0, e1, nr;
              valid = 1'b1; cls = 3'(c); lo = 3'(a); sz = 2'(s);
              le = l[0]; wt = p[0]; ci = p[1];
              @(negedge clk);
              e0 = exp_cause(c, a, s, l, p & 1, p >> 1, 1'b1);
              e1 = exp_cause(c, a, s, l, p & 1, p >> 1, 1'b0);
              nr = n_rules(c, a, s, l, p & 1, p >> 1);
              check(tag_of(e0, nr), exc0, cau0, e0 != 0, e0);
              check((c == 1) ? "R8" : tag_of(e1, nr), exc1, cau1, e1 != 0, e1);
              if (p == 3 && l == 1) begin
                // R9: the same stimulus with valid low must not trap
                valid = 1'b0;
                @(negedge clk);
                check("R9", exc0, cau0, 0, 0);
                check("R9", exc1, cau1, 0, 0);
              end
            end
    check("R7", 0, int'(vec1), 0, 'h600);
    valid = 1'b0;
    @(negedge clk);
    check("R9", exc0, cau0, 0, 0);
    finish_run();
  end
endmodule